// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Port Controller

This block is a full-duplex synchronous serial port that a CPU drives through three byte-wide registers. One register sets the mode, the speed and the interrupt enable. One holds the status flags. The third is the data register, which is written to send and read to fetch the last byte received. A single shift register serves both directions, so every byte sent out is matched by one byte taken in. Completed receptions are copied into a separate read buffer.

As a master, the block makes the serial clock itself by dividing the system clock by 4, 16, 64 or 128. A data write while the port is idle starts a transfer. As a slave, the block takes the serial clock, the incoming data line and an active-low select from outside, and passes them through two-flop synchronizers. It moves data only while it is selected. Clock and data follow SPI mode 0: the clock idles low, data is sampled on the rising edge and changes on the falling edge, and the most significant bit goes first. If the CPU writes the data register during a transfer, the write is refused and a collision flag is set. Each flag is cleared by writing a 1 to its bit.

Top module: `spi_ctl_top`

## Requirements
- R1: After reset, the control and status registers read 0 and the read buffer reads 0. The output enables `sclk_oe`, `mosi_oe` and `miso_oe` are 0, and `irq` is 0.
- R2: While the enable bit (control bit 0) is 0, no serial line is driven and `sclk_out` never toggles. A data write then starts no transfer and sets no flag.
- R3: With enable set and master (control bit 1) set, a write to the data register (address 2) while idle starts a transfer. The byte goes out on `mosi_out` MSB first. `sclk_out` idles low, and `mosi_out` changes only when `sclk_out` falls.
- R4: In master mode, the serial clock period in system clocks is set by the rate field, control bits 4:3. The codes 0, 1, 2 and 3 give 4, 16, 64 and 128.
- R5: As a master, the block samples `miso_in` on each rising serial clock edge. After the eighth bit, the byte received is copied into the read buffer, and reads of the data register return it.
- R6: The done flag, status bit 0, is set when 8 bits have been shifted. `irq` is high while the done flag is set and the interrupt enable (control bit 2) is 1. With the interrupt enable at 0, `irq` stays 0.
- R7: A data write while a transfer is active sets the collision flag, status bit 1. The byte being sent is unchanged, and the refused byte is not sent later.
- R8: Writing 1 to a status bit clears that flag. Writing 0 to a status bit leaves it as it was.
- R9: In slave mode (enable set, master clear), while `ss_n_in` is low, the block drives `miso_oe` high. It shifts out the last byte written MSB first, changing it after falling `sclk_in` edges. It takes in `mosi_in` on rising `sclk_in` edges. After 8 bits it sets the done flag and fills the read buffer.
- R10: In slave mode, while `ss_n_in` is high, `miso_oe` is 0 and `sclk_in` is ignored. A deselect part-way through a byte drops the partial byte without setting the done flag, and the next selection starts again from the MSB.
- R11: Register reads are registered. `reg_rdata` shows the register at `reg_addr` one clock after the address is applied, using address 0 for control, 1 for status and 2 for data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Write strobe for one clock |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| sclk_out | output | 1 | Serial clock driven as master |
| sclk_oe | output | 1 | Drive enable for the serial clock |
| sclk_in | input | 1 | Serial clock received as slave |
| mosi_out | output | 1 | Master data out |
| mosi_oe | output | 1 | Drive enable for master data out |
| mosi_in | input | 1 | Data received as slave |
| miso_out | output | 1 | Slave data out |
| miso_oe | output | 1 | Drive enable for slave data out |
| miso_in | input | 1 | Data received as master |
| ss_n_in | input | 1 | Active-low slave select |

## Verification
The assertions assume that a slave-mode serial clock runs at a quarter of the system clock or slower. They also assume that `mosi_in` is stable for several system clocks around each rising `sclk_in` edge, so the synchronized copies see each level and each edge exactly once. The bench drives the slave side with half-periods of eight system clocks, and it changes `mosi_in` and `ss_n_in` only while the serial clock is low. In master mode the assertions assume `miso_in` does not change near a rising serial clock edge, so the bench's slave model updates it only after a falling edge.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

  // register addresses
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_DATA = 2'd2
  } reg_addr_e;

  // control field positions
  localparam int unsigned CTRL_EN   = 0;
  localparam int unsigned CTRL_MST  = 1;
  localparam int unsigned CTRL_IE   = 2;
  localparam int unsigned CTRL_RATE = 3;
  localparam int unsigned CTRL_W    = 5;

  // status field positions
  localparam int unsigned STAT_DONE = 0;
  localparam int unsigned STAT_WCOL = 1;

  // divider counter width; must hold the largest half period minus one
  localparam int unsigned DIV_CNT_W = 7;

  // half of the serial clock period, in system clocks
  function automatic int unsigned half_period(input logic [1:0] rate);
    case (rate)
      2'd0:    return 2;
      2'd1:    return 8;
      2'd2:    return 32;
      default: return 64;
    endcase
  endfunction

endpackage

// File: rtl/spi_clkgen.sv
module spi_clkgen
  import spi_ctl_pkg::*;
#(
  parameter int unsigned CNT_W = DIV_CNT_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim  = CNT_W'(half_period(rate) - 1);
    tick = run && (cnt == lim);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == lim) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned     W       = 3,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int unsigned CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain <= {chain[CHAIN_W-W-1:0], d};
    end
  end

  assign q = chain[CHAIN_W-1 -: W];

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              master,
  input  logic              tick,
  input  logic              start,
  input  logic [DATA_W-1:0] load_val,
  input  logic              miso_raw,
  input  logic              s_sclk,
  input  logic              s_mosi,
  input  logic              s_ss,
  output logic              busy,
  output logic              sclk_q,
  output logic              shift_msb,
  output logic              done_pulse,
  output logic [DATA_W-1:0] rx_byte
);

  localparam int unsigned     BC_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BC_W-1:0] LAST = BC_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] sh_next;
  logic [BC_W-1:0]   bitcnt;
  logic              sample;
  logic              m_busy;
  logic              sclk_d;
  logic              ss_d;
  logic              sel;
  logic              s_rise;
  logic              s_fall;
  logic              s_select;

  always_comb begin
    sel      = !s_ss;
    s_rise   = sel && s_sclk && !sclk_d;
    s_fall   = sel && !s_sclk && sclk_d;
    s_select = ss_d && !s_ss;
    sh_next  = {sh[DATA_W-2:0], sample};
    busy     = master ? m_busy : sel;
  end

  assign shift_msb = sh[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh         <= '0;
      bitcnt     <= '0;
      sample     <= 1'b0;
      m_busy     <= 1'b0;
      sclk_q     <= 1'b0;
      sclk_d     <= 1'b0;
      ss_d       <= 1'b1;
      done_pulse <= 1'b0;
      rx_byte    <= '0;
    end else begin
      sclk_d     <= s_sclk;
      ss_d       <= s_ss;
      done_pulse <= 1'b0;
      if (!en) begin
        m_busy <= 1'b0;
        sclk_q <= 1'b0;
        bitcnt <= '0;
      end else if (master) begin
        if (!m_busy) begin
          if (start) begin
            sh     <= load_val;
            m_busy <= 1'b1;
            bitcnt <= '0;
            sclk_q <= 1'b0;
          end
        end else if (tick) begin
          if (!sclk_q) begin
            // leading edge: capture the incoming bit
            sclk_q <= 1'b1;
            sample <= miso_raw;
          end else begin
            // trailing edge: shift, next bit appears on the line
            sclk_q <= 1'b0;
            sh     <= sh_next;
            if (bitcnt == LAST) begin
              m_busy     <= 1'b0;
              done_pulse <= 1'b1;
              rx_byte    <= sh_next;
              bitcnt     <= '0;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
      end else begin
        m_busy <= 1'b0;
        sclk_q <= 1'b0;
        if (s_select) begin
          sh     <= load_val;
          bitcnt <= '0;
        end else if (!sel) begin
          bitcnt <= '0;
        end else if (s_rise) begin
          sample <= s_mosi;
        end else if (s_fall) begin
          if (bitcnt == LAST) begin
            sh         <= load_val;
            rx_byte    <= sh_next;
            done_pulse <= 1'b1;
            bitcnt     <= '0;
          end else begin
            sh     <= sh_next;
            bitcnt <= bitcnt + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_ctl_top.sv
module spi_ctl_top
  import spi_ctl_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              sclk_in,
  output logic              mosi_out,
  output logic              mosi_oe,
  input  logic              mosi_in,
  output logic              miso_out,
  output logic              miso_oe,
  input  logic              miso_in,
  input  logic              ss_n_in
);

  localparam int unsigned SYNC_W = 3;

  logic [CTRL_W-1:0] ctrl_q;
  logic              ctrl_en;
  logic              ctrl_master;
  logic              ctrl_ie;
  logic [1:0]        ctrl_rate;
  logic              done_f;
  logic              wcol_f;
  logic [DATA_W-1:0] rbuf;
  logic [DATA_W-1:0] tx_hold;
  logic [DATA_W-1:0] load_val;
  logic              ctrl_wr;
  logic              stat_wr;
  logic              data_wr;
  logic              start;
  logic              collide;
  logic              busy;
  logic              tick;
  logic              sclk_q;
  logic              shift_msb;
  logic              done_pulse;
  logic [DATA_W-1:0] rx_byte;
  logic [SYNC_W-1:0] sync_q;
  logic              s_sclk;
  logic              s_mosi;
  logic              s_ss;

  always_comb begin
    ctrl_en     = ctrl_q[CTRL_EN];
    ctrl_master = ctrl_q[CTRL_MST];
    ctrl_ie     = ctrl_q[CTRL_IE];
    ctrl_rate   = ctrl_q[CTRL_RATE +: 2];
    ctrl_wr     = reg_wr && (reg_addr == ADDR_CTRL);
    stat_wr     = reg_wr && (reg_addr == ADDR_STAT);
    data_wr     = reg_wr && (reg_addr == ADDR_DATA);
    collide     = data_wr && ctrl_en && busy;
    start       = data_wr && ctrl_en && ctrl_master && !busy;
    load_val    = ctrl_master ? reg_wdata : tx_hold;
    s_ss        = sync_q[2];
    s_mosi      = sync_q[1];
    s_sclk      = sync_q[0];
  end

  spi_in_sync #(
    .W       (SYNC_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ss_n_in, mosi_in, sclk_in}),
    .q   (sync_q)
  );

  spi_clkgen #(
    .CNT_W (DIV_CNT_W)
  ) u_clkgen (
    .clk  (clk),
    .rst  (rst),
    .run  (ctrl_en && ctrl_master && busy),
    .rate (ctrl_rate),
    .tick (tick)
  );

  spi_shift_engine #(
    .DATA_W (DATA_W)
  ) u_engine (
    .clk        (clk),
    .rst        (rst),
    .en         (ctrl_en),
    .master     (ctrl_master),
    .tick       (tick),
    .start      (start),
    .load_val   (load_val),
    .miso_raw   (miso_in),
    .s_sclk     (s_sclk),
    .s_mosi     (s_mosi),
    .s_ss       (s_ss),
    .busy       (busy),
    .sclk_q     (sclk_q),
    .shift_msb  (shift_msb),
    .done_pulse (done_pulse),
    .rx_byte    (rx_byte)
  );

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      done_f  <= 1'b0;
      wcol_f  <= 1'b0;
      rbuf    <= '0;
      tx_hold <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q <= reg_wdata[CTRL_W-1:0];
      end
      if (data_wr && !collide) begin
        tx_hold <= reg_wdata;
      end
      if (done_pulse) begin
        rbuf <= rx_byte;
      end
      done_f <= done_pulse || (done_f && !(stat_wr && reg_wdata[STAT_DONE]));
      wcol_f <= collide    || (wcol_f && !(stat_wr && reg_wdata[STAT_WCOL]));
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
      sclk_oe   <= 1'b0;
      mosi_oe   <= 1'b0;
      miso_oe   <= 1'b0;
    end else begin
      case (reg_addr)
        ADDR_CTRL: reg_rdata <= DATA_W'(ctrl_q);
        ADDR_STAT: reg_rdata <= DATA_W'({wcol_f, done_f});
        ADDR_DATA: reg_rdata <= rbuf;
        default:   reg_rdata <= '0;
      endcase
      irq     <= ctrl_ie && done_f;
      sclk_oe <= ctrl_en && ctrl_master;
      mosi_oe <= ctrl_en && ctrl_master;
      miso_oe <= ctrl_en && !ctrl_master && !s_ss;
    end
  end

  assign sclk_out = sclk_q;
  assign mosi_out = shift_msb;
  assign miso_out = shift_msb;

endmodule

// File: rtl/spi_ctl_chk.sv
module spi_ctl_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic master,
  input logic busy,
  input logic data_wr,
  input logic sclk_out,
  input logic sclk_oe,
  input logic mosi_oe,
  input logic miso_oe,
  input logic mosi_out,
  input logic wcol_f,
  input logic done_f,
  input logic irq,
  input logic s_ss
);

  p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!sclk_oe && !mosi_oe && !miso_oe));

  p_clock_idles_low_r3: assert property (@(posedge clk) disable iff (rst)
    (en && master && !busy) |-> !sclk_out);

  p_data_still_at_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_out) |-> $stable(mosi_out));

  p_data_still_while_high_r3: assert property (@(posedge clk) disable iff (rst)
    (sclk_out && $past(sclk_out)) |-> $stable(mosi_out));

  p_collision_flagged_r7: assert property (@(posedge clk) disable iff (rst)
    (data_wr && en && busy) |=> wcol_f);

  p_irq_needs_done_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(done_f));

  p_miso_released_r10: assert property (@(posedge clk) disable iff (rst)
    s_ss |=> !miso_oe);

endmodule

bind spi_ctl_top spi_ctl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (ctrl_en),
  .master   (ctrl_master),
  .busy     (busy),
  .data_wr  (data_wr),
  .sclk_out (sclk_out),
  .sclk_oe  (sclk_oe),
  .mosi_oe  (mosi_oe),
  .miso_oe  (miso_oe),
  .mosi_out (mosi_out),
  .wcol_f   (wcol_f),
  .done_f   (done_f),
  .irq      (irq),
  .s_ss     (s_ss)
);

// File: tb/spi_ctl_top_tb.sv
module spi_ctl_top_tb;
  import spi_ctl_pkg::*;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq;
  logic       sclk_out, sclk_oe, sclk_in;
  logic       mosi_out, mosi_oe, mosi_in;
  logic       miso_out, miso_oe, miso_in;
  logic       ss_n_in;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit finished = 1'b0;

  // {rate, byte sent by DUT, byte returned by the slave model}
  localparam logic [17:0] VECS [5] = '{
    {2'd0, 8'hA5, 8'h3C},
    {2'd1, 8'h5A, 8'hC3},
    {2'd2, 8'hFF, 8'h00},
    {2'd3, 8'h01, 8'h80},
    {2'd0, 8'h00, 8'hFF}
  };

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_ctl_top u_dut (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .sclk_out  (sclk_out),
    .sclk_oe   (sclk_oe),
    .sclk_in   (sclk_in),
    .mosi_out  (mosi_out),
    .mosi_oe   (mosi_oe),
    .mosi_in   (mosi_in),
    .miso_out  (miso_out),
    .miso_oe   (miso_oe),
    .miso_in   (miso_in),
    .ss_n_in   (ss_n_in)
  );

  function automatic int exp_period(input logic [1:0] r);
    case (r)
      2'd0:    return 4;
      2'd1:    return 16;
      2'd2:    return 64;
      default: return 128;
    endcase
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    reg_wr   = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // bench plays the slave while the DUT is master
  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] rx, input bit coll,
                             output logic [7:0] got, output int period);
    int t0;
    t0 = 0;
    period = 0;
    miso_in = rx[7];
    reg_write(ADDR_DATA, tx);
    for (int i = 7; i >= 0; i--) begin
      @(posedge sclk_out);
      @(negedge clk);
      got[i] = mosi_out;
      if (i == 7) t0 = cyc;
      if (i == 6) period = cyc - t0;
      if (coll && i == 4) reg_write(ADDR_DATA, 8'h3C);
      @(negedge sclk_out);
      if (i > 0) miso_in = rx[i-1];
    end
  endtask

  // bench plays the master while the DUT is slave; select is left low
  task automatic slave_xfer(input logic [7:0] to_dut, input int nbits,
                            output logic [7:0] from_dut);
    from_dut = '0;
    ss_n_in = 1'b0;
    repeat (8) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      mosi_in = to_dut[7-b];
      repeat (8) @(negedge clk);
      from_dut[7-b] = miso_out;
      sclk_in = 1'b1;
      repeat (8) @(negedge clk);
      sclk_in = 1'b0;
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R3 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] got;
    int         per;
    bit         toggled;

    rst = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    sclk_in = 1'b0; mosi_in = 1'b0; miso_in = 1'b0; ss_n_in = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1", "sclk_oe", sclk_oe, 0);
    check("R1", "mosi_oe", mosi_oe, 0);
    check("R1", "miso_oe", miso_oe, 0);
    check("R1", "irq", irq, 0);
    reg_read(ADDR_CTRL, rd); check("R1", "ctrl", rd, 8'h00);
    reg_read(ADDR_STAT, rd); check("R1", "status", rd, 8'h00);
    reg_read(ADDR_DATA, rd); check("R1", "data", rd, 8'h00);

    // R2 disabled: master bit alone, then a data write
    reg_write(ADDR_CTRL, 8'h02);
    reg_read(ADDR_CTRL, rd); check("R11", "ctrl readback", rd, 8'h02);
    reg_write(ADDR_DATA, 8'h55);
    toggled = 1'b0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (sclk_out || sclk_oe || mosi_oe) toggled = 1'b1;
    end
    check("R2", "lines idle while disabled", toggled, 0);
    reg_read(ADDR_STAT, rd); check("R2", "no flag while disabled", rd, 8'h00);

    // vector table: master transfers at every rate
    foreach (VECS[v]) begin
      logic [1:0] rate;
      logic [7:0] tx, rx;
      {rate, tx, rx} = VECS[v];
      reg_write(ADDR_CTRL, 8'h07 | {3'b000, rate, 3'b000});
      master_xfer(tx, rx, 1'b0, got, per);
      check("R3", "mosi byte", got, tx);
      check("R4", "sclk period", per, exp_period(rate));
      repeat (4) @(negedge clk);
      check("R6", "irq raised", irq, 1);
      reg_read(ADDR_STAT, rd); check("R6", "done flag", rd, 8'h01);
      reg_read(ADDR_DATA, rd); check("R5", "rx byte", rd, rx);
      reg_write(ADDR_STAT, 8'h01);
      reg_read(ADDR_STAT, rd); check("R8", "done cleared", rd, 8'h00);
      check("R6", "irq dropped", irq, 0);
    end

    // R6 interrupt disabled
    reg_write(ADDR_CTRL, 8'h03);
    master_xfer(8'h6E, 8'h91, 1'b0, got, per);
    repeat (4) @(negedge clk);
    check("R6", "irq masked", irq, 0);
    reg_read(ADDR_STAT, rd); check("R6", "done without irq", rd, 8'h01);
    reg_write(ADDR_STAT, 8'h01);

    // R7 collision in master mode at rate code 2
    reg_write(ADDR_CTRL, 8'h13);
    master_xfer(8'h96, 8'h69, 1'b1, got, per);
    check("R7", "byte unchanged by collision", got, 8'h96);
    repeat (4) @(negedge clk);
    reg_read(ADDR_DATA, rd); check("R5", "rx after collision", rd, 8'h69);
    reg_read(ADDR_STAT, rd); check("R7", "both flags", rd, 8'h03);
    reg_write(ADDR_STAT, 8'h02);
    reg_read(ADDR_STAT, rd); check("R8", "only wcol cleared", rd, 8'h01);
    reg_write(ADDR_STAT, 8'h01);
    toggled = 1'b0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (sclk_out) toggled = 1'b1;
    end
    check("R7", "refused byte not sent", toggled, 0);

    // R9 slave transfer
    reg_write(ADDR_CTRL, 8'h01);
    reg_write(ADDR_DATA, 8'hC6);
    slave_xfer(8'h4B, 8, got);
    check("R9", "miso byte", got, 8'hC6);
    check("R9", "miso driven while selected", miso_oe, 1);
    reg_read(ADDR_STAT, rd); check("R9", "slave done", rd, 8'h01);
    reg_read(ADDR_DATA, rd); check("R9", "slave rx", rd, 8'h4B);
    reg_write(ADDR_DATA, 8'h11);
    reg_read(ADDR_STAT, rd); check("R7", "slave collision", rd, 8'h03);
    ss_n_in = 1'b1;
    repeat (8) @(negedge clk);
    check("R10", "miso released", miso_oe, 0);
    reg_write(ADDR_STAT, 8'h03);

    // R10 abort mid-byte, clocks while deselected, then a clean restart
    reg_write(ADDR_DATA, 8'hE1);
    slave_xfer(8'hFF, 3, got);
    ss_n_in = 1'b1;
    repeat (8) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      sclk_in = 1'b1; repeat (8) @(negedge clk);
      sclk_in = 1'b0; repeat (8) @(negedge clk);
    end
    reg_read(ADDR_STAT, rd); check("R10", "no done after abort", rd, 8'h00);
    reg_read(ADDR_DATA, rd); check("R10", "buffer kept", rd, 8'h4B);
    slave_xfer(8'hB4, 8, got);
    ss_n_in = 1'b1;
    check("R10", "restart from msb", got, 8'hE1);
    reg_read(ADDR_DATA, rd); check("R10", "rx after restart", rd, 8'hB4);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule